// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block guards a battery-backed static memory against corruption while its supply is collapsing or recovering. Two comparators report whether the supply is above the write-protect level and above the switchover level. Their flags reach the block asynchronously. The block synchronizes and qualifies them and tracks the supply condition in a four-state machine. From that state it gates the host's chip, write and output enables to the memory, tells the output pads when to float, and picks whether the memory is powered from the main rail or from the backup cell.

A one-time seal keeps the backup cell disconnected from the moment of reset. The seal stays in force until the supply first reaches the protect level and holds there. Once broken, the seal cannot be restored without a reset.

A parameter picks the supply-tolerance variant, and with it the comparator setpoint that the block publishes. The setpoint is lower while the memory is accessible and higher while it is protected, which gives the comparator hysteresis. All pins are plain level control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `pwrfail_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the block in the sealed state: sealed=1, protect=1, sel_backup=0, and every memory enable is 0.
- R2: thresh_mv publishes the trip setpoint in millivolts. While protect=0 it is 4375 (TIGHT_TOL=0) or 4625 (TIGHT_TOL=1). While protect=1 it is the resume level, 4500 or 4750.
- R3: Each comparator flag passes through two synchronizing flops. A fall of trip_ok_async while the memory is accessible raises protect on the third rising clock edge after the fall.
- R4: A rising flag is acted on only after its synchronized value has been high for HOLD_CYC consecutive clocks. A high pulse shorter than that changes no output, and a dip restarts the count.
- R5: While protect=1, mem_ce, mem_we and mem_oe are 0 and out_hiz=1 in the same cycle, whatever the host drives. This also cuts short an access that is already in progress.
- R6: While the seal is broken, a fall of swo_ok_async moves the block to backup (sel_backup=1, sel_main=0). sel_main and sel_backup are never 1 together.
- R7: In backup, a qualified rise of the switchover flag returns the block to the main supply (sel_main=1) while keeping protect=1. Access resumes only after a further qualified rise of the trip flag.
- R8: The seal (sealed=1) is released only by a qualified trip-level rise. It is never re-armed afterwards except by reset.
- R9: While sealed, sel_main follows the synchronized switchover flag. While sealed with that flag low, both selects are 0 and unpowered=1. unpowered is 0 in every other case.
- R10: While accessible, mem_ce=host_ce and mem_we=host_we, and mem_oe=host_oe only when host_we=0; an active write forces mem_oe=0. out_hiz = not(mem_ce and mem_oe).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_ok_async | input | 1 | Comparator flag: supply above the write-protect setpoint |
| swo_ok_async | input | 1 | Comparator flag: supply above the switchover level |
| host_ce | input | 1 | Host chip enable, active high |
| host_we | input | 1 | Host write enable, active high |
| host_oe | input | 1 | Host output enable, active high |
| mem_ce | output | 1 | Gated chip enable to the memory |
| mem_we | output | 1 | Gated write enable to the memory |
| mem_oe | output | 1 | Gated output enable to the memory |
| out_hiz | output | 1 | Memory data outputs float when 1 |
| protect | output | 1 | Write protection in force |
| sel_main | output | 1 | Memory powered from the main supply |
| sel_backup | output | 1 | Memory powered from the backup cell |
| sealed | output | 1 | Backup cell still sealed |
| unpowered | output | 1 | Sealed with the supply below the switchover level |
| thresh_mv | output | 13 | Comparator trip setpoint in millivolts |

## Verification
The bench builds the block with TIGHT_TOL=1 and HOLD_CYC=3. The short hold window makes sub-threshold glitches and exact qualification latencies cheap to reach in a few cycles. The tight variant exercises the setpoint switching between 4625 and 4750. With these values, a glitch of two clocks must be rejected and one of three clocks accepted. The cycle-accurate reference model then fixes the edge at which every transition lands, including a simultaneous loss of both flags.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_SEALED = 2'd0,
    ST_NORMAL = 2'd1,
    ST_PROT   = 2'd2,
    ST_BACKUP = 2'd3
  } pfs_state_t;

  localparam int NFLAG  = 2;
  localparam int F_TRIP = 0;
  localparam int F_SWO  = 1;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/pfs_qualify.sv
module pfs_qualify #(
  parameter int W    = 2,
  parameter int HOLD = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] held
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  for (genvar i = 0; i < W; i++) begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !lvl[i]) cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
    assign held[i] = (cnt == LIMIT);

    // R4
    held_needs_level_chk: assert property (@(posedge clk) disable iff (rst)
      held[i] |-> $past(lvl[i]));
  end
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trip_lvl,
  input  logic       swo_lvl,
  input  logic       trip_held,
  input  logic       swo_held,
  output pfs_state_t st
);
  pfs_state_t st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_SEALED: if (trip_held) st_nxt = ST_NORMAL;
      ST_NORMAL: if (!trip_lvl) st_nxt = ST_PROT;
      ST_PROT: begin
        if (!swo_lvl)       st_nxt = ST_BACKUP;
        else if (trip_held) st_nxt = ST_NORMAL;
      end
      ST_BACKUP: if (swo_held) st_nxt = ST_PROT;
      default:   st_nxt = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_SEALED;
    else     st <= st_nxt;
  end

  // R8
  no_reseal_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_SEALED) |=> (st != ST_SEALED));
  // R3
  trip_loss_protects_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORMAL && !trip_lvl) |=> (st == ST_PROT));
  // R4
  resume_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st == ST_NORMAL) |-> $past(trip_held));
  // R7
  backup_exits_to_prot_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st == ST_BACKUP) |-> (st == ST_PROT));
endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
  import pfs_pkg::*;
#(
  parameter int TIGHT_TOL = 0,
  parameter int HOLD_CYC  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trip_ok_async,
  input  logic        swo_ok_async,
  input  logic        host_ce,
  input  logic        host_we,
  input  logic        host_oe,
  output logic        mem_ce,
  output logic        mem_we,
  output logic        mem_oe,
  output logic        out_hiz,
  output logic        protect,
  output logic        sel_main,
  output logic        sel_backup,
  output logic        sealed,
  output logic        unpowered,
  output logic [12:0] thresh_mv
);
  localparam logic [12:0] TRIP_MV   = (TIGHT_TOL != 0) ? 13'd4625 : 13'd4375;
  localparam logic [12:0] RESUME_MV = (TIGHT_TOL != 0) ? 13'd4750 : 13'd4500;

  logic [NFLAG-1:0] raw, lvl, held;
  pfs_state_t       st;
  logic             open_acc;

  assign raw[F_TRIP] = trip_ok_async;
  assign raw[F_SWO]  = swo_ok_async;

  pfs_sync #(.W(NFLAG)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(lvl)
  );

  pfs_qualify #(.W(NFLAG), .HOLD(HOLD_CYC)) u_qual (
    .clk(clk), .rst(rst), .lvl(lvl), .held(held)
  );

  pfs_fsm u_fsm (
    .clk(clk), .rst(rst),
    .trip_lvl(lvl[F_TRIP]), .swo_lvl(lvl[F_SWO]),
    .trip_held(held[F_TRIP]), .swo_held(held[F_SWO]),
    .st(st)
  );

  assign open_acc   = (st == ST_NORMAL);
  assign protect    = !open_acc;
  assign sealed     = (st == ST_SEALED);
  assign sel_backup = (st == ST_BACKUP);
  assign sel_main   = open_acc || (st == ST_PROT) || (sealed && lvl[F_SWO]);
  assign unpowered  = sealed && !lvl[F_SWO];
  assign thresh_mv  = protect ? RESUME_MV : TRIP_MV;

  assign mem_ce  = host_ce && open_acc;
  assign mem_we  = host_we && open_acc;
  assign mem_oe  = host_oe && !host_we && open_acc;
  assign out_hiz = !(mem_ce && mem_oe);

  // R5
  protect_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    protect |-> (!mem_ce && !mem_we && !mem_oe && out_hiz));
  // R6
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_main && sel_backup));
  // R9
  unpowered_only_sealed_chk: assert property (@(posedge clk) disable iff (rst)
    unpowered |-> (sealed && !sel_main && !sel_backup));
  // R10
  write_kills_oe_chk: assert property (@(posedge clk) disable iff (rst)
    host_we |-> !mem_oe);
endmodule

// File: tb/tb_pwrfail_seq.sv
module tb_pwrfail_seq;
  localparam int HOLD = 3;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip_raw = 1'b0, swo_raw = 1'b0;
  logic host_ce = 1'b0, host_we = 1'b0, host_oe = 1'b0;
  logic mem_ce, mem_we, mem_oe, out_hiz, protect, sel_main, sel_backup, sealed, unpowered;
  logic [12:0] thresh_mv;

  int vectors = 0, miscompares = 0, cycles = 0;

  always #4 clk = ~clk;

  pwrfail_seq #(.TIGHT_TOL(1), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst(rst), .trip_ok_async(trip_raw), .swo_ok_async(swo_raw),
    .host_ce(host_ce), .host_we(host_we), .host_oe(host_oe),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_oe(mem_oe), .out_hiz(out_hiz),
    .protect(protect), .sel_main(sel_main), .sel_backup(sel_backup),
    .sealed(sealed), .unpowered(unpowered), .thresh_mv(thresh_mv)
  );

  // behavioural reference: 0 sealed, 1 accessible, 2 protected, 3 backup
  int m_st = 0;
  bit m_t1, m_t2, m_s1, m_s2;
  int m_ct, m_cs;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_t1 = 0; m_t2 = 0; m_s1 = 0; m_s2 = 0; m_ct = 0; m_cs = 0;
    end else begin
      if (m_st == 0 && m_ct == HOLD) m_st = 1;
      else if (m_st == 1 && !m_t2) m_st = 2;
      else if (m_st == 2 && !m_s2) m_st = 3;
      else if (m_st == 2 && m_ct == HOLD) m_st = 1;
      else if (m_st == 3 && m_cs == HOLD) m_st = 2;
      m_ct = m_t2 ? ((m_ct < HOLD) ? m_ct + 1 : m_ct) : 0;
      m_cs = m_s2 ? ((m_cs < HOLD) ? m_cs + 1 : m_cs) : 0;
      m_t2 = m_t1; m_t1 = trip_raw;
      m_s2 = m_s1; m_s1 = swo_raw;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit acc;
      int e_ce, e_oe;
      acc  = (m_st == 1);
      e_ce = host_ce && acc;
      e_oe = host_oe && !host_we && acc;
      chk("R3 protect", protect, !acc);
      chk("R2 thresh_mv", thresh_mv, acc ? 4625 : 4750);
      chk("R8 sealed", sealed, m_st == 0);
      chk("R6 sel_backup", sel_backup, m_st == 3);
      chk("R7 sel_main", sel_main, (m_st == 1) || (m_st == 2) || (m_st == 0 && m_s2));
      chk("R9 unpowered", unpowered, m_st == 0 && !m_s2);
      chk("R5 mem_ce", mem_ce, e_ce);
      chk("R5 mem_we", mem_we, host_we && acc);
      chk("R10 mem_oe", mem_oe, e_oe);
      chk("R10 out_hiz", out_hiz, !(e_ce && e_oe));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 sealed after reset", sealed, 1);
    chk("R1 protect after reset", protect, 1);
    chk("R1 sel_backup after reset", sel_backup, 0);
    chk("R9 unpowered while sealed", unpowered, 1);
    host_ce = 1; host_we = 1;
    tick(1);
    chk("R1 mem_we gated when sealed", mem_we, 0);
    host_ce = 0; host_we = 0;

    swo_raw = 1;
    tick(4);
    chk("R9 sealed main selected", sel_main, 1);
    chk("R9 unpowered cleared", unpowered, 0);

    // R4 short trip glitch rejected
    trip_raw = 1; tick(2); trip_raw = 0;
    tick(6);
    chk("R4 glitch keeps seal", sealed, 1);

    trip_raw = 1;
    tick(2 + HOLD + 2);
    chk("R8 seal broken", sealed, 0);
    chk("R2 trip setpoint", thresh_mv, 4625);

    // R10 write and read
    host_ce = 1; host_we = 1; host_oe = 1;
    tick(1);
    chk("R10 write kills oe", mem_oe, 0);
    chk("R10 write passes", mem_we, 1);
    host_we = 0;
    tick(1);
    chk("R10 read drives", out_hiz, 0);

    // R3 latency of trip loss, access in progress
    trip_raw = 0;
    tick(2);
    chk("R3 protect not yet", protect, 0);
    tick(1);
    chk("R3 protect on third edge", protect, 1);
    chk("R5 read cut short", out_hiz, 1);
    chk("R2 resume setpoint", thresh_mv, 4750);
    host_ce = 0; host_oe = 0;

    swo_raw = 0;
    tick(4);
    chk("R6 backup selected", sel_backup, 1);
    chk("R6 main dropped", sel_main, 0);
    chk("R8 no reseal", sealed, 0);

    // R4 dip restarts count
    swo_raw = 1; tick(2); swo_raw = 0; tick(1); swo_raw = 1;
    tick(3);
    chk("R4 dip restarts", sel_backup, 1);
    tick(HOLD + 2);
    chk("R7 back on main", sel_main, 1);
    chk("R7 still protected", protect, 1);

    trip_raw = 1;
    tick(2 + HOLD + 2);
    chk("R7 access resumes", protect, 0);

    // both flags lost together
    trip_raw = 0; swo_raw = 0;
    tick(3);
    chk("R3 both lost protect", protect, 1);
    tick(1);
    chk("R6 both lost backup", sel_backup, 1);
    chk("R8 seal stays broken", sealed, 0);

    // R1 reset re-arms, then supply absent
    rst = 1; tick(2); rst = 0; tick(1);
    chk("R1 reset reseals", sealed, 1);
    chk("R9 unpowered after reset", unpowered, 1);
    chk("R9 no backup while sealed", sel_backup, 0);
    tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule